// File: doc/BRIEF.md
# Accumulator Processor Core

A small processor built around one 16-bit accumulator. It runs programs held in an internal word-addressed memory with a 12-bit address space. Before a run, the program and its data are written into that memory through a preload stream. A start pulse then launches execution at address 0x100. Each instruction is fetched, decoded and executed in a fixed sequence of clock cycles. The core runs until it executes a halt word. It then freezes its registers and memory until the next reset.

An instruction word holds three fields: an indirect flag in bit 15, an opcode in bits 14..12 and an address in bits 11..0. The memory-reference operations are load, store and jump. Each of them uses either the address field directly or the address found through one extra memory read. Opcode 111 with bit 15 clear selects register operations. In that case bits 11..0 act as one-hot commands: complement, skip-if-non-negative and halt. Any other opcode only advances the program counter.

The preload port is a valid/ready stream. A word is written only in a cycle where both `ld_valid` and `ld_ready` are high. `ld_ready` is high only while the core is idle, which means after reset and before start. A sender holding `ld_valid` during a run or after halt is back-pressured indefinitely, until the next reset. `start`, the accumulator, program counter and halted outputs are plain level signals.

Top module: `acc_cpu`

## Requirements
- R1: Reset sets the program counter to 0x100, the accumulator to 0, halted low and ld_ready high. Memory contents are left as they were before reset.
- R2: Preload words are accepted only in cycles where ld_valid and ld_ready are both high. ld_ready is high only in the idle state. While running or halted, ld_ready is low and the memory is not written by the preload port.
- R3: A start pulse in the idle state begins execution. Every instruction takes 3 clock cycles, plus 1 more for an indirect memory reference. halted rises on the edge that ends the halt instruction.
- R4: A word with bit 15 clear and opcode bits 14..12 = 010 loads the accumulator from the memory word at bits 11..0.
- R5: Opcode 011 writes the accumulator into the memory word at the effective address.
- R6: With bit 15 set and an opcode other than 111, the effective address is bits 11..0 of the memory word at the address field. This costs one extra cycle.
- R7: Opcode 100 sets the program counter to the effective address, so a word with leading hex digit C jumps through an indirect pointer.
- R8: Register word 0x7200 (bit 9) inverts every bit of the accumulator.
- R9: Register word 0x7010 (bit 4) adds one more to the program counter only when accumulator bit 15 is 0.
- R10: Register word 0x7001 (bit 0) halts the core. While halted, the program counter, accumulator and memory hold their values, and start is ignored until reset.
- R11: Opcodes 000, 001, 101 and 110, and opcode 111 with bit 15 set, change nothing but advance the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin execution from the idle state |
| ld_valid | input | 1 | Preload word offered |
| ld_ready | output | 1 | Preload word can be accepted (idle only) |
| ld_addr | input | 12 | Preload memory address |
| ld_data | input | 16 | Preload memory word |
| ac_out | output | 16 | Accumulator |
| pc_out | output | 12 | Program counter |
| halted | output | 1 | Core has executed a halt word |

## Verification
Timing is checked against the edge that samples start. halted must rise exactly three edges per direct instruction and four per indirect one after that edge. The bench counts edges one at a time and compares the count with the sum worked out from each program. Accumulator and program counter values are read only once halted is seen, at the falling edge after it rises. Stored words are observed by resetting and running a second program that loads them back. The same readback shows that preload attempts made while halted were refused.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam logic [2:0] OPC_LOAD  = 3'b010;
  localparam logic [2:0] OPC_STORE = 3'b011;
  localparam logic [2:0] OPC_JUMP  = 3'b100;
  localparam logic [2:0] OPC_REG   = 3'b111;

  localparam int RR_CMA_BIT = 9;
  localparam int RR_SPA_BIT = 4;
  localparam int RR_HLT_BIT = 0;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DECODE,
    ST_INDIR,
    ST_EXEC,
    ST_HALT
  } state_e;

  typedef struct packed {
    logic is_load;
    logic is_store;
    logic is_jump;
    logic is_reg;
    logic indirect;
    logic rr_cma;
    logic rr_spa;
    logic rr_hlt;
  } dec_t;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[waddr] <= wdata;
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
  import acc_cpu_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic [WORD_W-1:0] ir,
  output dec_t              dec,
  output logic [ADDR_W-1:0] addr
);
  logic       ind_bit;
  logic [2:0] opc;
  logic       memref;

  assign ind_bit = ir[WORD_W-1];
  assign opc     = ir[WORD_W-2 -: 3];
  assign addr    = ir[ADDR_W-1:0];
  assign memref  = (opc != OPC_REG);

  always_comb begin
    dec          = '0;
    dec.indirect = ind_bit && memref;
    dec.is_load  = (opc == OPC_LOAD);
    dec.is_store = (opc == OPC_STORE);
    dec.is_jump  = (opc == OPC_JUMP);
    dec.is_reg   = (opc == OPC_REG) && !ind_bit;
    dec.rr_cma   = dec.is_reg && addr[RR_CMA_BIT];
    dec.rr_spa   = dec.is_reg && addr[RR_SPA_BIT];
    dec.rr_hlt   = dec.is_reg && addr[RR_HLT_BIT];
  end
endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int              WORD_W   = 16,
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] RESET_PC = 12'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [WORD_W-1:0] mem_rdata,
  input  dec_t              dec,
  input  logic [ADDR_W-1:0] dec_addr,
  output logic [WORD_W-1:0] ir,
  output logic [ADDR_W-1:0] mem_raddr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic [WORD_W-1:0] ac,
  output logic [ADDR_W-1:0] pc,
  output logic              halted,
  output logic              ld_ready
);
  state_e            state;
  logic [ADDR_W-1:0] ar;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      pc    <= RESET_PC;
      ac    <= '0;
      ir    <= '0;
      ar    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) state <= ST_FETCH;
        ST_FETCH: begin
          ir    <= mem_rdata;
          pc    <= pc + 1'b1;
          state <= ST_DECODE;
        end
        ST_DECODE: begin
          ar    <= dec_addr;
          state <= dec.indirect ? ST_INDIR : ST_EXEC;
        end
        ST_INDIR: begin
          ar    <= mem_rdata[ADDR_W-1:0];
          state <= ST_EXEC;
        end
        ST_EXEC: begin
          if (dec.is_load) ac <= mem_rdata;
          if (dec.is_jump) pc <= ar;
          if (dec.rr_cma)  ac <= ~ac;
          if (dec.rr_spa && !ac[WORD_W-1]) pc <= pc + 1'b1;
          state <= dec.rr_hlt ? ST_HALT : ST_FETCH;
        end
        ST_HALT: state <= ST_HALT;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ld_ready  = (state == ST_IDLE);
    halted    = (state == ST_HALT);
    mem_raddr = (state == ST_FETCH) ? pc : ar;
    mem_we    = (ld_ready && ld_valid) || ((state == ST_EXEC) && dec.is_store);
    mem_waddr = ld_ready ? ld_addr : ar;
    mem_wdata = ld_ready ? ld_data : ac;
  end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int                WORD_W   = 16,
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] RESET_PC = 12'h100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data,
  output logic [WORD_W-1:0] ac_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic              halted
);
  logic [WORD_W-1:0] ir;
  dec_t              dec;
  logic [ADDR_W-1:0] dec_addr;
  logic [ADDR_W-1:0] mem_raddr;
  logic [WORD_W-1:0] mem_rdata;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [WORD_W-1:0] mem_wdata;

  acc_cpu_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  acc_cpu_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_dec (
    .ir   (ir),
    .dec  (dec),
    .addr (dec_addr)
  );

  acc_cpu_core #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_core (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .ld_valid  (ld_valid),
    .ld_addr   (ld_addr),
    .ld_data   (ld_data),
    .mem_rdata (mem_rdata),
    .dec       (dec),
    .dec_addr  (dec_addr),
    .ir        (ir),
    .mem_raddr (mem_raddr),
    .mem_we    (mem_we),
    .mem_waddr (mem_waddr),
    .mem_wdata (mem_wdata),
    .ac        (ac_out),
    .pc        (pc_out),
    .halted    (halted),
    .ld_ready  (ld_ready)
  );
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int WORD_W = 16,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              ld_ready,
  input logic [WORD_W-1:0] ac_out,
  input logic [ADDR_W-1:0] pc_out,
  input logic              halted
);
  // R10
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && $stable(pc_out) && $stable(ac_out)));

  // R2
  halt_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    halted |-> !ld_ready);

  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_ready && !start) |=> (ld_ready && $stable(pc_out) && $stable(ac_out)));

  // R3
  start_leave_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_ready && start) |=> (!ld_ready && !halted));

  // R2
  ready_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_ready, halted}));
endmodule

bind acc_cpu acc_cpu_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .start    (start),
  .ld_ready (ld_ready),
  .ac_out   (ac_out),
  .pc_out   (pc_out),
  .halted   (halted)
);

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] ac_out;
  logic [11:0] pc_out;
  logic        halted;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  acc_cpu dut (
    .clk(clk), .rst(rst), .start(start), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .ac_out(ac_out), .pc_out(pc_out), .halted(halted)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run(output int cyc);
    cyc = 0;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end while (!halted && cyc < 200);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 pc", pc_out, 12'h100);
    chk("R1 ac", ac_out, 0);
    chk("R1 halted", halted, 0);
    chk("R1 ld_ready", ld_ready, 1);
  endtask

  task automatic t_basic();
    int c;
    do_reset();
    put(12'h100, 16'h2105); put(12'h101, 16'h7010); put(12'h102, 16'h7200);
    put(12'h103, 16'h3106); put(12'h104, 16'h7001); put(12'h105, 16'hCAB4);
    put(12'h106, 16'h0000);
    run(c);
    chk("R3 cycles", c, 15);
    chk("R4 R8 ac", ac_out, 16'h354B);
    chk("R9 no skip pc", pc_out, 12'h105);
    chk("R10 halted", halted, 1);
    // hold while halted: start and preload both ignored
    repeat (5) @(negedge clk);
    start = 1'b1; ld_valid = 1'b1; ld_addr = 12'h106; ld_data = 16'h0000;
    chk("R2 ready low halted", ld_ready, 0);
    repeat (4) @(negedge clk);
    start = 1'b0; ld_valid = 1'b0;
    chk("R10 pc held", pc_out, 12'h105);
    chk("R10 ac held", ac_out, 16'h354B);
    chk("R10 still halted", halted, 1);
    // readback of stored word after reset
    do_reset();
    put(12'h100, 16'h2106); put(12'h101, 16'h7001);
    run(c);
    chk("R5 R1 R2 stored word", ac_out, 16'h354B);
    chk("R3 readback cycles", c, 6);
  endtask

  task automatic t_skip();
    int c;
    do_reset();
    put(12'h100, 16'h2110); put(12'h101, 16'h7010); put(12'h102, 16'h7200);
    put(12'h103, 16'h7001); put(12'h110, 16'h1234);
    run(c);
    chk("R9 skip ac", ac_out, 16'h1234);
    chk("R9 skip pc", pc_out, 12'h104);
    chk("R9 skip cycles", c, 9);
  endtask

  task automatic t_ind_load();
    int c;
    do_reset();
    put(12'h100, 16'hA110); put(12'h101, 16'h7001);
    put(12'h110, 16'h0120); put(12'h120, 16'hBEEF);
    run(c);
    chk("R6 indirect load ac", ac_out, 16'hBEEF);
    chk("R6 indirect cycles", c, 7);
  endtask

  task automatic t_jump();
    int c;
    do_reset();
    put(12'h100, 16'hC110); put(12'h110, 16'h0130);
    put(12'h130, 16'h2132); put(12'h131, 16'h7001); put(12'h132, 16'h5A5A);
    run(c);
    chk("R7 jump ac", ac_out, 16'h5A5A);
    chk("R7 jump pc", pc_out, 12'h132);
    chk("R7 jump cycles", c, 10);
  endtask

  task automatic t_noop();
    int c;
    do_reset();
    put(12'h100, 16'h2110); put(12'h101, 16'h1111); put(12'h102, 16'hF800);
    put(12'h103, 16'h7001); put(12'h110, 16'h00FF); put(12'h111, 16'h0001);
    run(c);
    chk("R11 noop ac", ac_out, 16'h00FF);
    chk("R11 noop pc", pc_out, 12'h104);
    chk("R11 noop cycles", c, 12);
  endtask

  task automatic t_ind_store();
    int c;
    do_reset();
    put(12'h100, 16'h2110); put(12'h101, 16'hB111); put(12'h102, 16'h7001);
    put(12'h110, 16'h7777); put(12'h111, 16'h0140); put(12'h140, 16'h0000);
    run(c);
    chk("R6 indirect store cycles", c, 10);
    do_reset();
    put(12'h100, 16'h2140); put(12'h101, 16'h7001);
    run(c);
    chk("R5 R6 indirect store word", ac_out, 16'h7777);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_skip();
    t_ind_load();
    t_jump();
    t_noop();
    t_ind_store();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule